// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns a decoded operand description into a memory or port reference for a 16-bit segmented processor. It takes a mode code and the current base, index and data register values, together with the displacement and address/immediate fields of the instruction, and an optional segment-override selector. From these it forms a 16-bit offset, chooses which segment register the later physical-address stage should use, and marks whether the operand lives in memory, in the port space, or in neither.

Each request is presented with a one-cycle valid strobe. The result appears on the registered outputs one clock later with its own one-cycle valid strobe, and it is held until the next request. Byte displacements are sign-extended before the add, and all offset arithmetic wraps within 16 bits. Immediate and register operands are passed through as non-memory results with a zero offset.

Top module: `ea_gen`

## Requirements
- R1: Mode code 2 (direct) gives an offset equal to `addr_field`, `is_mem`=1, and segment DS; segment codes are ES=0, CS=1, SS=2, DS=3.
- R2: Mode code 3 (register indirect) gives the register picked by `ind_sel` (0=BX, 1=BP, 2=SI, 3=DI) as the offset; the segment is SS when BP is picked and DS otherwise.
- R3: Mode code 4 (indexed) gives SI (`idx_sel`=0) or DI (`idx_sel`=1) plus the displacement, with segment DS.
- R4: When `disp_wide`=0 the displacement is `disp[7:0]` sign-extended to 16 bits and `disp[15:8]` has no effect; when `disp_wide`=1 all 16 bits of `disp` are used.
- R5: Mode code 5 (based) gives BP plus the displacement, with segment SS.
- R6: Mode code 6 (based-indexed) gives BP plus SI or DI (per `idx_sel`); mode code 7 adds the displacement to that sum; both use segment SS.
- R7: With `seg_ovr_en`=1 in any memory mode (codes 2 to 7), `seg_idx` equals `seg_ovr` instead of the default segment.
- R8: Offset sums wrap modulo 2^16; no carry leaves the offset.
- R9: Mode code 8 gives the port number `addr_field[7:0]` zero-extended, mode code 9 gives DX; both set `is_port`=1, `is_mem`=0, `seg_idx`=0, and ignore the override.
- R10: Mode codes 0 (immediate), 1 (register) and 10 to 15 give `is_mem`=0, `is_port`=0, offset 0 and `seg_idx`=0.
- R11: Outputs load on the clock edge where `in_valid`=1 and `out_valid` is high only in the following cycle; without `in_valid` the outputs hold their values.
- R12: While `rst_n` is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode code |
| idx_sel | input | 1 | Index register pick: 0=SI, 1=DI |
| ind_sel | input | 2 | Indirect register pick: 0=BX, 1=BP, 2=SI, 3=DI |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| reg_dx | input | 16 | DX value |
| disp | input | 16 | Displacement field |
| disp_wide | input | 1 | 1 = 16-bit displacement, 0 = byte displacement |
| addr_field | input | 16 | Direct address or immediate port field |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr | input | 2 | Override segment code |
| out_valid | output | 1 | Result strobe |
| offset | output | 16 | Effective offset or port number |
| seg_idx | output | 2 | Chosen segment code |
| is_mem | output | 1 | Operand is in memory |
| is_port | output | 1 | Operand is an I/O port |

## Verification
On every cycle the assertions check the strobe timing and output hold, that memory and port results never coincide, that non-memory results carry a zero offset and segment, and that an override on a memory request appears on the segment output. The actual offset arithmetic, the default segment choice per mode, the sign extension of byte displacements and the wrap at 16 bits can only be shown by the bench's directed scenarios, which compare each result with values worked out by hand.

// File: rtl/ea_pkg.sv
package ea_pkg;

    // Addressing mode codes
    localparam logic [3:0] MODE_IMM       = 4'd0;
    localparam logic [3:0] MODE_REG       = 4'd1;
    localparam logic [3:0] MODE_DIRECT    = 4'd2;
    localparam logic [3:0] MODE_REGIND    = 4'd3;
    localparam logic [3:0] MODE_INDEXED   = 4'd4;
    localparam logic [3:0] MODE_BASED     = 4'd5;
    localparam logic [3:0] MODE_BIDX      = 4'd6;
    localparam logic [3:0] MODE_BIDX_DISP = 4'd7;
    localparam logic [3:0] MODE_PORT_IMM  = 4'd8;
    localparam logic [3:0] MODE_PORT_DX   = 4'd9;

    // Segment codes
    localparam logic [1:0] SEG_ES = 2'd0;
    localparam logic [1:0] SEG_CS = 2'd1;
    localparam logic [1:0] SEG_SS = 2'd2;
    localparam logic [1:0] SEG_DS = 2'd3;

    // Indirect register picks
    localparam logic [1:0] IND_BX = 2'd0;
    localparam logic [1:0] IND_BP = 2'd1;
    localparam logic [1:0] IND_SI = 2'd2;
    localparam logic [1:0] IND_DI = 2'd3;

    function automatic logic mode_is_mem(input logic [3:0] m);
        return (m >= MODE_DIRECT) && (m <= MODE_BIDX_DISP);
    endfunction

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int AW = 16,
    parameter int NB = 8
) (
    input  logic [AW-1:0] disp_raw,
    input  logic          wide,
    output logic [AW-1:0] disp_ext
);
    generate
        if (AW > NB) begin : g_ext
            localparam int PAD = AW - NB;
            logic [AW-1:0] narrow_ext;
            always_comb begin
                narrow_ext = {{PAD{disp_raw[NB-1]}}, disp_raw[NB-1:0]};
                disp_ext   = wide ? disp_raw : narrow_ext;
            end
        end else begin : g_pass
            logic unused_wide;
            always_comb begin
                unused_wide = wide;
                disp_ext    = disp_raw;
            end
        end
    endgenerate
endmodule

// File: rtl/ea_term_sel.sv
module ea_term_sel
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int PB = 8
) (
    input  logic [3:0]    mode,
    input  logic          idx_sel,
    input  logic [1:0]    ind_sel,
    input  logic [AW-1:0] reg_bx,
    input  logic [AW-1:0] reg_bp,
    input  logic [AW-1:0] reg_si,
    input  logic [AW-1:0] reg_di,
    input  logic [AW-1:0] reg_dx,
    input  logic [AW-1:0] disp_ext,
    input  logic [AW-1:0] addr_field,
    output logic [AW-1:0] term_base,
    output logic [AW-1:0] term_index,
    output logic [AW-1:0] term_disp,
    output logic          uses_bp,
    output logic          mem_ref,
    output logic          port_ref
);
    logic [AW-1:0] index_val;
    logic [AW-1:0] ind_val;
    logic [AW-1:0] port_imm;

    always_comb begin
        index_val = idx_sel ? reg_di : reg_si;
        port_imm  = '0;
        port_imm[PB-1:0] = addr_field[PB-1:0];
        unique case (ind_sel)
            IND_BX:  ind_val = reg_bx;
            IND_BP:  ind_val = reg_bp;
            IND_SI:  ind_val = reg_si;
            default: ind_val = reg_di;
        endcase
    end

    always_comb begin
        term_base  = '0;
        term_index = '0;
        term_disp  = '0;
        uses_bp    = 1'b0;
        mem_ref    = 1'b0;
        port_ref   = 1'b0;
        case (mode)
            MODE_DIRECT: begin
                term_base = addr_field;
                mem_ref   = 1'b1;
            end
            MODE_REGIND: begin
                term_base = ind_val;
                uses_bp   = (ind_sel == IND_BP);
                mem_ref   = 1'b1;
            end
            MODE_INDEXED: begin
                term_index = index_val;
                term_disp  = disp_ext;
                mem_ref    = 1'b1;
            end
            MODE_BASED: begin
                term_base = reg_bp;
                term_disp = disp_ext;
                uses_bp   = 1'b1;
                mem_ref   = 1'b1;
            end
            MODE_BIDX: begin
                term_base  = reg_bp;
                term_index = index_val;
                uses_bp    = 1'b1;
                mem_ref    = 1'b1;
            end
            MODE_BIDX_DISP: begin
                term_base  = reg_bp;
                term_index = index_val;
                term_disp  = disp_ext;
                uses_bp    = 1'b1;
                mem_ref    = 1'b1;
            end
            MODE_PORT_IMM: begin
                term_base = port_imm;
                port_ref  = 1'b1;
            end
            MODE_PORT_DX: begin
                term_base = reg_dx;
                port_ref  = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [AW-1:0] sum
);
    // Wraps modulo 2^AW: the carry out is dropped on purpose
    always_comb begin
        sum = a + b + c;
    end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
    import ea_pkg::*;
(
    input  logic       mem_ref,
    input  logic       uses_bp,
    input  logic       ovr_en,
    input  logic [1:0] ovr_seg,
    output logic [1:0] seg
);
    always_comb begin
        if (!mem_ref)
            seg = SEG_ES;
        else if (ovr_en)
            seg = ovr_seg;
        else if (uses_bp)
            seg = SEG_SS;
        else
            seg = SEG_DS;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DB = 8,
    parameter int PB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    mode,
    input  logic          idx_sel,
    input  logic [1:0]    ind_sel,
    input  logic [AW-1:0] reg_bx,
    input  logic [AW-1:0] reg_bp,
    input  logic [AW-1:0] reg_si,
    input  logic [AW-1:0] reg_di,
    input  logic [AW-1:0] reg_dx,
    input  logic [AW-1:0] disp,
    input  logic          disp_wide,
    input  logic [AW-1:0] addr_field,
    input  logic          seg_ovr_en,
    input  logic [1:0]    seg_ovr,
    output logic          out_valid,
    output logic [AW-1:0] offset,
    output logic [1:0]    seg_idx,
    output logic          is_mem,
    output logic          is_port
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] off;
        logic [1:0]    seg;
        logic          mem;
        logic          port;
    } ea_state_t;

    ea_state_t st_d, st_q;

    logic [AW-1:0] disp_ext_w;
    logic [AW-1:0] t_base, t_index, t_disp, sum_w;
    logic          uses_bp_w, mem_w, port_w;
    logic [1:0]    seg_w;

    ea_disp_ext #(.AW(AW), .NB(DB)) u_disp (
        .disp_raw (disp),
        .wide     (disp_wide),
        .disp_ext (disp_ext_w)
    );

    ea_term_sel #(.AW(AW), .PB(PB)) u_terms (
        .mode       (mode),
        .idx_sel    (idx_sel),
        .ind_sel    (ind_sel),
        .reg_bx     (reg_bx),
        .reg_bp     (reg_bp),
        .reg_si     (reg_si),
        .reg_di     (reg_di),
        .reg_dx     (reg_dx),
        .disp_ext   (disp_ext_w),
        .addr_field (addr_field),
        .term_base  (t_base),
        .term_index (t_index),
        .term_disp  (t_disp),
        .uses_bp    (uses_bp_w),
        .mem_ref    (mem_w),
        .port_ref   (port_w)
    );

    ea_sum3 #(.AW(AW)) u_sum (
        .a   (t_base),
        .b   (t_index),
        .c   (t_disp),
        .sum (sum_w)
    );

    ea_seg_pick u_seg (
        .mem_ref (mem_w),
        .uses_bp (uses_bp_w),
        .ovr_en  (seg_ovr_en),
        .ovr_seg (seg_ovr),
        .seg     (seg_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.off  = sum_w;
            st_d.seg  = seg_w;
            st_d.mem  = mem_w;
            st_d.port = port_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign offset    = st_q.off;
    assign seg_idx   = st_q.seg;
    assign is_mem    = st_q.mem;
    assign is_port   = st_q.port;

    // Strobe timing and hold
    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(offset) && $stable(seg_idx) && $stable(is_mem));

    // Memory and port results are exclusive
    assert_mem_port_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_mem && is_port));

    // Non-memory, non-port results are zero
    assert_nonmem_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_mem && !is_port) |-> (offset == '0 && seg_idx == 2'd0));

    // Override lands on the segment output for memory requests
    assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seg_ovr_en && mode_is_mem(mode)) |=> (seg_idx == $past(seg_ovr)));

    // Port results never carry a segment
    assert_port_seg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_port |-> seg_idx == 2'd0);
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        idx_sel = 1'b0;
    logic [1:0]  ind_sel = '0;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0, reg_dx = '0;
    logic [15:0] disp = '0;
    logic        disp_wide = 1'b0;
    logic [15:0] addr_field = '0;
    logic        seg_ovr_en = 1'b0;
    logic [1:0]  seg_ovr = '0;
    logic        out_valid;
    logic [15:0] offset;
    logic [1:0]  seg_idx;
    logic        is_mem, is_port;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .idx_sel(idx_sel), .ind_sel(ind_sel),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .reg_dx(reg_dx), .disp(disp), .disp_wide(disp_wide),
        .addr_field(addr_field), .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr),
        .out_valid(out_valid), .offset(offset), .seg_idx(seg_idx),
        .is_mem(is_mem), .is_port(is_port)
    );

    task automatic check(input string req, input logic v, input logic [15:0] off,
                         input logic [1:0] seg, input logic m, input logic p);
        n_chk++;
        if (out_valid !== v || offset !== off || seg_idx !== seg ||
            is_mem !== m || is_port !== p) begin
            n_bad++;
            $display("FAIL %s: got v=%b off=%h seg=%0d mem=%b port=%b, exp v=%b off=%h seg=%0d mem=%b port=%b",
                     req, out_valid, offset, seg_idx, is_mem, is_port, v, off, seg, m, p);
        end
    endtask

    // Issue one request at a falling edge, sample after the capturing edge
    task automatic issue(input logic [3:0] md);
        mode = md;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 reset", 1'b0, 16'h0000, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_direct;
        seg_ovr_en = 1'b0;
        addr_field = 16'h1234;
        issue(4'd2);
        check("R1 direct", 1'b1, 16'h1234, 2'd3, 1'b1, 1'b0);
    endtask

    task automatic t_regind;
        reg_bx = 16'h2000; reg_bp = 16'h3000; reg_si = 16'h4000; reg_di = 16'h5000;
        ind_sel = 2'd0; issue(4'd3);
        check("R2 indirect BX", 1'b1, 16'h2000, 2'd3, 1'b1, 1'b0);
        ind_sel = 2'd1; issue(4'd3);
        check("R2 indirect BP", 1'b1, 16'h3000, 2'd2, 1'b1, 1'b0);
        ind_sel = 2'd3; issue(4'd3);
        check("R2 indirect DI", 1'b1, 16'h5000, 2'd3, 1'b1, 1'b0);
    endtask

    task automatic t_indexed;
        reg_si = 16'h0100; reg_di = 16'h0200;
        idx_sel = 1'b0; disp_wide = 1'b0; disp = 16'h7FF0;
        issue(4'd4);
        check("R3 R4 indexed SI byte -16", 1'b1, 16'h00F0, 2'd3, 1'b1, 1'b0);
        idx_sel = 1'b1; disp_wide = 1'b1; disp = 16'h1000;
        issue(4'd4);
        check("R3 R4 indexed DI word", 1'b1, 16'h1200, 2'd3, 1'b1, 1'b0);
        idx_sel = 1'b1; disp_wide = 1'b0; disp = 16'hFF05;
        issue(4'd4);
        check("R4 byte +5 upper ignored", 1'b1, 16'h0205, 2'd3, 1'b1, 1'b0);
    endtask

    task automatic t_based;
        reg_bp = 16'h0500; disp_wide = 1'b0;
        disp = 16'h0004; issue(4'd5);
        check("R5 based +4", 1'b1, 16'h0504, 2'd2, 1'b1, 1'b0);
        disp = 16'h00FC; issue(4'd5);
        check("R5 R4 based -4", 1'b1, 16'h04FC, 2'd2, 1'b1, 1'b0);
    endtask

    task automatic t_bidx;
        reg_bp = 16'h1000; reg_di = 16'h0020; reg_si = 16'h0040; disp_wide = 1'b0; disp = 16'h0002;
        idx_sel = 1'b1; issue(4'd6);
        check("R6 BP+DI", 1'b1, 16'h1020, 2'd2, 1'b1, 1'b0);
        idx_sel = 1'b0; issue(4'd7);
        check("R6 BP+SI+2", 1'b1, 16'h1042, 2'd2, 1'b1, 1'b0);
    endtask

    task automatic t_wrap;
        reg_bp = 16'hFFF0; reg_si = 16'h0020; idx_sel = 1'b0;
        disp_wide = 1'b1; disp = 16'h0001;
        issue(4'd7);
        check("R8 wrap", 1'b1, 16'h0011, 2'd2, 1'b1, 1'b0);
    endtask

    task automatic t_override;
        reg_bp = 16'h0500; disp_wide = 1'b0; disp = 16'h0004;
        seg_ovr_en = 1'b1; seg_ovr = 2'd0;
        issue(4'd5);
        check("R7 override ES on based", 1'b1, 16'h0504, 2'd0, 1'b1, 1'b0);
        seg_ovr = 2'd1; addr_field = 16'hBEEF;
        issue(4'd2);
        check("R7 override CS on direct", 1'b1, 16'hBEEF, 2'd1, 1'b1, 1'b0);
        seg_ovr = 2'd3; reg_dx = 16'h03F8;
        issue(4'd9);
        check("R9 override ignored on port", 1'b1, 16'h03F8, 2'd0, 1'b0, 1'b1);
        seg_ovr_en = 1'b0;
    endtask

    task automatic t_port;
        addr_field = 16'hAB80;
        issue(4'd8);
        check("R9 port immediate", 1'b1, 16'h0080, 2'd0, 1'b0, 1'b1);
        reg_dx = 16'h1234;
        issue(4'd9);
        check("R9 port DX", 1'b1, 16'h1234, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_nonmem;
        addr_field = 16'h5555;
        issue(4'd0);
        check("R10 immediate", 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0);
        issue(4'd1);
        check("R10 register", 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0);
        issue(4'd15);
        check("R10 unused code", 1'b1, 16'h0000, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        addr_field = 16'h0ACE;
        issue(4'd2);
        check("R11 load", 1'b1, 16'h0ACE, 2'd3, 1'b1, 1'b0);
        addr_field = 16'h7777; mode = 4'd8;
        @(negedge clk);
        check("R11 hold no strobe", 1'b0, 16'h0ACE, 2'd3, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 hold two", 1'b0, 16'h0ACE, 2'd3, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_regind();
        t_indexed();
        t_based();
        t_bidx();
        t_wrap();
        t_override();
        t_port();
        t_nonmem();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no finish, exp finish within 5000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule